// File: doc/BRIEF.md
# DMA Status Read Retry Controller

This block sits between a bus interface unit and an audio engine and guards the DMA status read port. When another bus master reads that port before the audio engine has fresh status ready, the block answers the read with a retry. It then raises its own bus request, so that it can fetch the status itself. When that self-initiated read finishes normally, it pulses a write strobe that hands the data to the audio engine.

If the foreign master keeps being retried and the status never arrives, the block gives up after a bounded number of retries. At that point it cancels its pending bus request and raises a sticky error flag. From then on it ignores every foreign status read until reset.

When the audio engine reports status ready, a read of the port is passed through for normal decoding instead of being retried. Address decoding compares 16 bits.

Top module: `dsr_retry_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, retry_o, bus_req_o, status_wr_o, err_o and decode_en_o are all 0.
- R2: A foreign status read is a cycle with rd_req_i=1 and rd_addr_i equal to STATUS_PORT (default 16'h0008) in all 16 bits. If such a read arrives while status_rdy_i=0, own_master_i=0 and err_o=0, retry_o is 1 in the next cycle for exactly one cycle.
- R3: Every retry sets bus_req_o in the same cycle as retry_o. bus_req_o stays 1 until the cycle after gnt_i=1 is sampled without a new retry, or until err_o is set.
- R4: self_done_i=1 with err_o=0 gives a one-cycle status_wr_o pulse in the next cycle and clears the retry count. If a retry and self_done_i fall in the same cycle, the clear wins.
- R5: The MAX_RETRY-th retry (default 3) since reset or since the last status_wr_o sets err_o in the same cycle as that retry_o, and bus_req_o is 0 in that cycle.
- R6: Once err_o is 1 it stays 1 until reset. While it is 1, foreign status reads produce no retry_o and no decode_en_o, bus_req_o stays 0, and self_done_i produces no status_wr_o.
- R7: A foreign status read with status_rdy_i=1 and err_o=0 sets decode_en_o for one cycle in the next cycle. It does not retry and does not count.
- R8: A read whose address differs from STATUS_PORT in any of the 16 bits is ignored: no retry, no decode, no count.
- R9: A status read seen while own_master_i=1 produces no retry and no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req_i | input | 1 | An I/O read cycle is presented this clock |
| rd_addr_i | input | 16 | I/O address of the read |
| own_master_i | input | 1 | This device is currently the bus master |
| gnt_i | input | 1 | Bus grant for the pending request |
| self_done_i | input | 1 | The self-initiated status read ended normally |
| status_rdy_i | input | 1 | Audio engine holds valid status |
| retry_o | output | 1 | Answer the current foreign read with retry |
| bus_req_o | output | 1 | Request bus ownership to fetch the status |
| status_wr_o | output | 1 | Write strobe carrying the fetched status to the audio engine |
| err_o | output | 1 | Sticky give-up flag |
| decode_en_o | output | 1 | Let the status port decode normally |

## Verification
Every output is registered, so each result is due exactly one clock after the edge that samples its stimulus. This holds for the retry, the request set or clear, the write strobe, the error flag and the decode enable. The bench changes inputs on the falling edge and advances its behavioural model by one step with the same inputs. It then compares all five outputs at the following falling edge, which lies one full register stage later. The tests include retry runs interrupted by a status write, a retry that coincides with completion, grants, reset during error, and a random phase.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
   typedef enum logic [1:0] {
      RD_NONE   = 2'd0,
      RD_RETRY  = 2'd1,
      RD_DECODE = 2'd2,
      RD_IGNORE = 2'd3
   } rd_action_e;

   typedef struct packed {
      logic retry;
      logic decode;
      logic wr;
   } dsr_pulse_t;

   localparam int unsigned DSR_DEC_W = 16;
endpackage

// File: rtl/dsr_port_dec.sv
module dsr_port_dec #(
   parameter int unsigned ADDR_W = 16,
   parameter logic [15:0] STATUS_PORT = 16'h0008
) (
   input  logic              rd_req_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic              hit_o
);
   import dsr_pkg::*;
   localparam int unsigned DEC_W = DSR_DEC_W;

   generate
      if (ADDR_W < DEC_W) begin : g_bad
         initial $error("dsr_port_dec: ADDR_W must be at least 16");
         assign hit_o = 1'b0;
      end else if (ADDR_W == DEC_W) begin : g_exact
         assign hit_o = rd_req_i && (rd_addr_i == STATUS_PORT);
      end else begin : g_wide
         logic upper_zero;
         assign upper_zero = (rd_addr_i[ADDR_W-1:DEC_W] == '0);
         assign hit_o = rd_req_i && upper_zero &&
                        (rd_addr_i[DEC_W-1:0] == STATUS_PORT);
      end
   endgenerate
endmodule

// File: rtl/dsr_retry_cnt.sv
module dsr_retry_cnt #(
   parameter int unsigned MAX_RETRY = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc_i,
   input  logic clr_i,
   output logic last_o
);
   localparam int unsigned CNT_W = $clog2(MAX_RETRY + 1);
   localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(MAX_RETRY - 1);

   generate
      if (MAX_RETRY < 1) begin : g_bad
         initial $error("dsr_retry_cnt: MAX_RETRY must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   assign last_o = inc_i && !clr_i && (cnt_q == LAST_VAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (inc_i && (cnt_q != LAST_VAL)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/dsr_bus_req.sv
module dsr_bus_req (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic gnt_i,
   input  logic kill_i,
   output logic req_o
);
   logic req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
      end else if (kill_i) begin
         req_q <= 1'b0;
      end else if (set_i) begin
         req_q <= 1'b1;
      end else if (gnt_i) begin
         req_q <= 1'b0;
      end
   end

   assign req_o = req_q;
endmodule

// File: rtl/dsr_retry_ctrl.sv
module dsr_retry_ctrl #(
   parameter int unsigned ADDR_W      = 16,
   parameter logic [15:0] STATUS_PORT = 16'h0008,
   parameter int unsigned MAX_RETRY   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic              own_master_i,
   input  logic              gnt_i,
   input  logic              self_done_i,
   input  logic              status_rdy_i,
   output logic              retry_o,
   output logic              bus_req_o,
   output logic              status_wr_o,
   output logic              err_o,
   output logic              decode_en_o
);
   import dsr_pkg::*;

   logic       hit;
   logic       last_retry;
   logic       err_q;
   rd_action_e action;
   dsr_pulse_t pulse_d, pulse_q;
   logic       do_retry;
   logic       do_wr;

   dsr_port_dec #(.ADDR_W(ADDR_W), .STATUS_PORT(STATUS_PORT)) u_dec (
      .rd_req_i (rd_req_i),
      .rd_addr_i(rd_addr_i),
      .hit_o    (hit)
   );

   always_comb begin
      action = RD_NONE;
      if (hit) begin
         if (err_q)             action = RD_IGNORE;
         else if (status_rdy_i) action = RD_DECODE;
         else if (!own_master_i) action = RD_RETRY;
         else                   action = RD_NONE;
      end
   end

   assign do_retry = (action == RD_RETRY);
   assign do_wr    = self_done_i && !err_q;

   dsr_retry_cnt #(.MAX_RETRY(MAX_RETRY)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (do_retry),
      .clr_i (do_wr),
      .last_o(last_retry)
   );

   dsr_bus_req u_req (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (do_retry),
      .gnt_i (gnt_i),
      .kill_i(err_q || last_retry),
      .req_o (bus_req_o)
   );

   always_comb begin
      pulse_d.retry  = do_retry;
      pulse_d.decode = (action == RD_DECODE);
      pulse_d.wr     = do_wr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q <= '0;
         err_q   <= 1'b0;
      end else begin
         pulse_q <= pulse_d;
         if (last_retry) err_q <= 1'b1;
      end
   end

   assign retry_o     = pulse_q.retry;
   assign decode_en_o = pulse_q.decode;
   assign status_wr_o = pulse_q.wr;
   assign err_o       = err_q;
endmodule

// File: rtl/dsr_retry_chk.sv
module dsr_retry_chk #(
   parameter int unsigned ADDR_W      = 16,
   parameter logic [15:0] STATUS_PORT = 16'h0008
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_req_i,
   input logic [ADDR_W-1:0] rd_addr_i,
   input logic              own_master_i,
   input logic              self_done_i,
   input logic              status_rdy_i,
   input logic              retry_o,
   input logic              bus_req_o,
   input logic              status_wr_o,
   input logic              err_o,
   input logic              decode_en_o
);
   logic port_rd;
   assign port_rd = rd_req_i && (rd_addr_i == ADDR_W'(STATUS_PORT));

   // R2
   retry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retry_o |-> $past(port_rd && !status_rdy_i && !own_master_i));

   // R3
   retry_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (retry_o && !err_o) |-> bus_req_o);

   // R4
   wr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_wr_o |-> $past(self_done_i && !err_o));

   // R5
   err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> (retry_o && !bus_req_o));

   // R6
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);

   // R6
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(err_o) |-> (!retry_o && !decode_en_o && !status_wr_o && !bus_req_o));

   // R7
   decode_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      decode_en_o |-> $past(port_rd && status_rdy_i));

   // R7
   excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({retry_o, decode_en_o}));
endmodule

bind dsr_retry_ctrl dsr_retry_chk #(.ADDR_W(ADDR_W), .STATUS_PORT(STATUS_PORT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_req_i    (rd_req_i),
   .rd_addr_i   (rd_addr_i),
   .own_master_i(own_master_i),
   .self_done_i (self_done_i),
   .status_rdy_i(status_rdy_i),
   .retry_o     (retry_o),
   .bus_req_o   (bus_req_o),
   .status_wr_o (status_wr_o),
   .err_o       (err_o),
   .decode_en_o (decode_en_o)
);

// File: tb/sim_dsr_retry_ctrl.sv
`timescale 1ns/1ps
module sim_dsr_retry_ctrl;
   localparam logic [15:0] PORT = 16'h0008;
   localparam int MAXR = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rd_req = 1'b0;
   logic [15:0] rd_addr = '0;
   logic own = 1'b0, gnt = 1'b0, done = 1'b0, rdy = 1'b0;
   logic retry, breq, swr, err, dec;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   // behavioural reference state
   int m_cnt = 0;
   bit m_err = 0, m_req = 0, m_retry = 0, m_wr = 0, m_dec = 0;

   always #4 clk = ~clk;

   dsr_retry_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .rd_req_i(rd_req), .rd_addr_i(rd_addr),
      .own_master_i(own), .gnt_i(gnt), .self_done_i(done), .status_rdy_i(rdy),
      .retry_o(retry), .bus_req_o(breq), .status_wr_o(swr), .err_o(err),
      .decode_en_o(dec)
   );

   task automatic cmp1(input string tag, input string nm, input bit act, input bit exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
      end
   endtask

   task automatic cmp_all(input string tag);
      cmp1(tag, "retry_o", retry, m_retry);
      cmp1(tag, "bus_req_o", breq, m_req);
      cmp1(tag, "status_wr_o", swr, m_wr);
      cmp1(tag, "err_o", err, m_err);
      cmp1(tag, "decode_en_o", dec, m_dec);
   endtask

   task automatic model_reset();
      m_cnt = 0; m_err = 0; m_req = 0; m_retry = 0; m_wr = 0; m_dec = 0;
   endtask

   // one clock: drive at falling edge, advance model, compare at next falling edge
   task automatic step(input string tag, input bit q, input logic [15:0] a,
                       input bit o, input bit g, input bit d, input bit r);
      bit hit;
      rd_req = q; rd_addr = a; own = o; gnt = g; done = d; rdy = r;
      hit = q && (a == PORT);
      if (m_err) begin
         m_retry = 0; m_dec = 0; m_wr = 0; m_req = 0;
      end else begin
         m_retry = hit && !r && !o;
         m_dec   = hit && r;
         m_wr    = d;
         if (d) m_cnt = 0;
         else if (m_retry) begin
            m_cnt++;
            if (m_cnt == MAXR) m_err = 1;
         end
         if (m_err) m_req = 0;
         else if (m_retry) m_req = 1;
         else if (g) m_req = 0;
      end
      @(posedge clk);
      @(negedge clk);
      cmp_all(tag);
   endtask

   task automatic idle(input string tag, input int n);
      for (int i = 0; i < n; i++) step(tag, 0, 16'h0, 0, 0, 0, 0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; rd_req = 0; own = 0; gnt = 0; done = 0; rdy = 0;
      model_reset();
      repeat (2) @(negedge clk);
      cmp_all("R1");
      rst_n = 1'b1;
      idle("R1", 1);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 20000);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         summary();
      end
   end

   initial begin
      do_reset();
      // R2 R3: retry, request held, then grant clears it
      step("R2", 1, PORT, 0, 0, 0, 0);
      step("R3", 0, 16'h0, 0, 0, 0, 0);
      step("R3", 0, 16'h0, 0, 1, 0, 0);
      // R4: fetch completes, strobe, count cleared
      step("R4", 0, 16'h0, 0, 0, 1, 0);
      idle("R4", 1);
      // R7: ready read decodes normally
      step("R7", 1, PORT, 0, 0, 0, 1);
      // R8: other addresses ignored, one bit off at either end
      step("R8", 1, 16'h0009, 0, 0, 0, 0);
      step("R8", 1, 16'h8008, 0, 0, 0, 0);
      // R9: own master gets no retry
      step("R9", 1, PORT, 1, 0, 0, 0);
      // R4: two retries, strobe clears, two more: no error
      step("R4", 1, PORT, 0, 0, 0, 0);
      step("R4", 1, PORT, 0, 0, 0, 0);
      step("R4", 0, 16'h0, 0, 1, 1, 0);
      step("R4", 1, PORT, 0, 0, 0, 0);
      step("R4", 1, PORT, 0, 0, 0, 0);
      // R4: retry together with completion, clear wins
      step("R4", 1, PORT, 0, 0, 1, 0);
      step("R5", 1, PORT, 0, 0, 0, 0);
      step("R5", 1, PORT, 0, 0, 0, 0);
      // R5: third retry since clear sets the error
      step("R5", 1, PORT, 0, 0, 0, 0);
      // R6: ignored after error
      step("R6", 1, PORT, 0, 0, 0, 0);
      step("R6", 1, PORT, 0, 0, 0, 1);
      step("R6", 0, 16'h0, 0, 0, 1, 0);
      idle("R6", 3);
      // R1 R6: only reset clears the error
      do_reset();
      step("R5", 1, PORT, 0, 0, 0, 0);
      step("R5", 1, PORT, 0, 1, 0, 0);
      step("R5", 1, PORT, 0, 0, 0, 0);
      idle("R6", 2);
      do_reset();
      // random phase covering R2..R9
      for (int i = 0; i < 3000; i++) begin
         bit q, o, g, d, r;
         logic [15:0] a;
         q = ($urandom % 2) == 0;
         a = (($urandom % 4) == 0) ? 16'($urandom) : PORT;
         o = ($urandom % 5) == 0;
         g = ($urandom % 3) == 0;
         d = ($urandom % 6) == 0;
         r = ($urandom % 4) == 0;
         step("R2_R9", q, a, o, g, d, r);
         if (($urandom % 200) == 0) do_reset();
      end
      finished = 1;
      summary();
   end
endmodule